// File: doc/BRIEF.md
# Multi-format Audio Serial Receiver

This block turns a serial audio data line into a pair of 32-bit parallel samples. It is a clock slave. The bit clock and the frame clock arrive as inputs and are sampled by the system clock, so each must stay high and low for at least two system-clock cycles. A data bit is taken when the system clock sees a rising bit-clock edge. The frame clock is read at that same instant.

Four framing styles are supported, and so are four word lengths. An optional two-slot time-division mode picks one word pair out of a wider frame. After capture, each output channel can take either received word, so the outputs can pass straight through, swap, or duplicate one channel. A one-cycle strobe marks each new stereo pair.

Top module: `aud_serial_rx`

## Requirements
- R1: `fmt` selects the framing: 00 right-aligned, 01 left-aligned, 10 one-bit-delayed, 11 pulse-framed. In left-aligned framing, the bit sampled at the first bit tick after a frame-clock change is the MSB, and later bits follow in order. Frame clock low marks the left half and high marks the right half.
- R2: In one-bit-delayed framing, the MSB is the bit sampled one bit tick after the frame-clock change. Frame clock low still marks the left half.
- R3: In right-aligned framing, the bit sampled just before a frame-clock change is the LSB of the word for the half that is ending. Bits received before the word are discarded.
- R4: In pulse-framed framing, the bit tick that first sees the frame clock high carries the left-word MSB. The right word follows straight after the left word's LSB.
- R5: `wordLen` sets the word length: 00=16, 01=20, 10=24, 11=32 bits. Each word is placed MSB-first at bit 31 of its output, and the unused low bits are zero.
- R6: Bit ticks that fall after a word's LSB and before the next frame start do not change the captured word.
- R7: `leftSrc`=0 sends the received left word to `leftOut`, and `leftSrc`=1 sends the received right word there.
- R8: `rightSrc`=0 sends the received left word to `rightOut`, and `rightSrc`=1 sends the received right word there.
- R9: With `tdmEn`=1, `tdmSlot` picks which slot is captured:
  - Left-aligned framing: slot 1's word follows slot 0's word within each half.
  - Pulse-framed framing: the frame order is L0, R0, L1, R1.
  - Right-aligned framing: slot 1 ends at the frame-clock change, and slot 0 sits just before it.
- R10: `outValid` is high for exactly one cycle once per frame, after the left and then the right word have been captured. `leftOut` and `rightOut` change only together with that strobe.
- R11: After reset, `leftOut` and `rightOut` are zero and `outValid` is low.
- R12: Data is sampled only on the rising bit-clock edge. A change on `sdata` while the bit clock is high has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Frame clock |
| sdata | input | 1 | Serial audio data |
| fmt | input | 2 | Framing style select |
| wordLen | input | 2 | Word length select |
| tdmEn | input | 1 | Two-slot mode enable |
| tdmSlot | input | 1 | Slot captured in two-slot mode |
| leftSrc | input | 1 | Source word for left output |
| rightSrc | input | 1 | Source word for right output |
| leftOut | output | 32 | Left sample, MSB-aligned |
| rightOut | output | 32 | Right sample, MSB-aligned |
| outValid | output | 1 | One-cycle new-sample strobe |

## Verification
Every idle bit tick in the test frames carries a one. A receiver that keeps shifting past the LSB, or that keeps early bits in right-aligned framing, therefore shows stray ones in the low bits. A receiver that starts one bit early or late in the delayed or pulse-framed styles returns a word shifted by one place. The two-slot runs fill both slots with different words, so capturing the wrong slot, or using the wrong offset in the right-aligned style, shows up at once. The data line is flipped while the bit clock is high, which exposes any sampling on the wrong edge. The swap and duplicate runs catch a source mux that is wired backwards.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  localparam int RX_IDX_W = 8;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_DLY = 2'b10,
    FMT_PLS = 2'b11
  } rxFmt_e;

  typedef struct packed {
    logic shiftEn;
    logic capture;
    logic capChan;
    logic offHi;
    logic useNew;
    logic done;
  } rxStrobe_t;

  function automatic logic [RX_IDX_W-1:0] wordBits(input logic [1:0] code);
    case (code)
      2'b00:   wordBits = 8'd16;
      2'b01:   wordBits = 8'd20;
      2'b10:   wordBits = 8'd24;
      default: wordBits = 8'd32;
    endcase
  endfunction
endpackage

// File: rtl/aud_rx_ctrl.sv
module aud_rx_ctrl
  import aud_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bclk,
  input  logic       lrclk,
  input  logic [1:0] fmt,
  input  logic [1:0] wordLen,
  input  logic       tdmEn,
  input  logic       tdmSlot,
  output rxStrobe_t  strb
);
  localparam logic [RX_IDX_W-1:0] IDX_MAX = '1;

  logic bclkQ, lrPrev, gotL;
  logic [RX_IDX_W-1:0] bitIdx, curIdx, wBits;
  logic [RX_IDX_W-1:0] posHalf, posPulse, endHalf, endL, endR;
  logic tick, trans, isDly;

  assign tick  = bclk & ~bclkQ;
  assign wBits = wordBits(wordLen);
  assign isDly = (fmt == FMT_DLY);
  assign trans = (fmt == FMT_PLS) ? (lrclk & ~lrPrev) : (lrclk ^ lrPrev);
  assign curIdx = trans ? '0 : bitIdx;

  assign posHalf  = {{(RX_IDX_W-1){1'b0}}, tdmEn & tdmSlot};
  assign posPulse = (tdmEn & tdmSlot) ? 8'd2 : 8'd0;
  assign endHalf  = wBits * (posHalf + 8'd1) - 8'd1 + {{(RX_IDX_W-1){1'b0}}, isDly};
  assign endL     = wBits * (posPulse + 8'd1) - 8'd1;
  assign endR     = wBits * (posPulse + 8'd2) - 8'd1;

  always_comb begin
    strb = '0;
    strb.shiftEn = tick;
    if (tick) begin
      if (fmt == FMT_RJ) begin
        strb.capture = trans;
        strb.capChan = lrPrev;
        strb.offHi   = tdmEn & ~tdmSlot;
        strb.useNew  = 1'b0;
      end else if (fmt == FMT_PLS) begin
        strb.useNew = 1'b1;
        if (curIdx == endL) begin
          strb.capture = 1'b1;
          strb.capChan = 1'b0;
        end else if (curIdx == endR) begin
          strb.capture = 1'b1;
          strb.capChan = 1'b1;
        end
      end else begin
        strb.useNew  = 1'b1;
        strb.capture = (curIdx == endHalf);
        strb.capChan = lrclk;
      end
    end
    strb.done = strb.capture & strb.capChan & gotL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkQ  <= 1'b0;
      lrPrev <= 1'b1;
      gotL   <= 1'b0;
      bitIdx <= '0;
    end else begin
      bclkQ <= bclk;
      if (tick) begin
        lrPrev <= lrclk;
        bitIdx <= (curIdx == IDX_MAX) ? IDX_MAX : curIdx + 8'd1;
      end
      if (strb.capture && !strb.capChan) gotL <= 1'b1;
      else if (strb.done)                gotL <= 1'b0;
    end
  end
endmodule

// File: rtl/aud_rx_datapath.sv
module aud_rx_datapath
  import aud_rx_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdata,
  input  logic [1:0]       wordLen,
  input  logic             leftSrc,
  input  logic             rightSrc,
  input  rxStrobe_t        strb,
  output logic [OUT_W-1:0] leftOut,
  output logic [OUT_W-1:0] rightOut,
  output logic             outValid
);
  localparam int SH_W = 2 * OUT_W;
  localparam logic [RX_IDX_W-1:0] OUT_W_I = RX_IDX_W'(OUT_W);

  logic [SH_W-1:0]     shiftReg, cand, seg;
  logic [OUT_W-1:0]    rxLeft, aligned;
  logic [RX_IDX_W-1:0] wBits;

  assign wBits   = wordBits(wordLen);
  // the word just completed, optionally including this tick's bit
  assign cand    = strb.useNew ? {shiftReg[SH_W-2:0], sdata} : shiftReg;
  assign seg     = cand >> (strb.offHi ? wBits : 8'd0);
  assign aligned = seg[OUT_W-1:0] << (OUT_W_I - wBits);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxLeft   <= '0;
      leftOut  <= '0;
      rightOut <= '0;
      outValid <= 1'b0;
    end else begin
      if (strb.shiftEn) shiftReg <= {shiftReg[SH_W-2:0], sdata};
      if (strb.capture && !strb.capChan) rxLeft <= aligned;
      outValid <= strb.done;
      if (strb.done) begin
        leftOut  <= leftSrc  ? aligned : rxLeft;
        rightOut <= rightSrc ? aligned : rxLeft;
      end
    end
  end
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bclk,
  input  logic             lrclk,
  input  logic             sdata,
  input  logic [1:0]       fmt,
  input  logic [1:0]       wordLen,
  input  logic             tdmEn,
  input  logic             tdmSlot,
  input  logic             leftSrc,
  input  logic             rightSrc,
  output logic [OUT_W-1:0] leftOut,
  output logic [OUT_W-1:0] rightOut,
  output logic             outValid
);
  rxStrobe_t strb;

  aud_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bclk(bclk), .lrclk(lrclk),
    .fmt(fmt), .wordLen(wordLen), .tdmEn(tdmEn), .tdmSlot(tdmSlot),
    .strb(strb)
  );

  aud_rx_datapath #(.OUT_W(OUT_W)) u_dp (
    .clk(clk), .rstN(rstN), .sdata(sdata), .wordLen(wordLen),
    .leftSrc(leftSrc), .rightSrc(rightSrc), .strb(strb),
    .leftOut(leftOut), .rightOut(rightOut), .outValid(outValid)
  );
endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk #(
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             bclk,
  input logic [1:0]       wordLen,
  input logic             leftSrc,
  input logic             rightSrc,
  input logic [OUT_W-1:0] leftOut,
  input logic [OUT_W-1:0] rightOut,
  input logic             outValid
);
  p_valid_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(leftOut) && $stable(rightOut)));

  p_rise_sample_r12: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(bclk) && !$past(bclk, 2)));

  p_dup_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ($past(leftSrc) == $past(rightSrc))) |-> (leftOut == rightOut));

  p_align16_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(wordLen) == 2'b00) |->
      (leftOut[OUT_W-17:0] == '0 && rightOut[OUT_W-17:0] == '0));
endmodule

bind aud_serial_rx aud_serial_rx_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rstN(rstN), .bclk(bclk), .wordLen(wordLen),
  .leftSrc(leftSrc), .rightSrc(rightSrc),
  .leftOut(leftOut), .rightOut(rightOut), .outValid(outValid)
);

// File: tb/tb_aud_serial_rx.sv
module tb_aud_serial_rx;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, bclk = 1'b0, lrclk = 1'b1, sdata = 1'b0;
  logic [1:0] fmt = 2'b01, wordLen = 2'b00;
  logic tdmEn = 1'b0, tdmSlot = 1'b0, leftSrc = 1'b0, rightSrc = 1'b1;
  logic [31:0] leftOut, rightOut;
  logic outValid;

  int nChecks = 0, nFails = 0, nValid = 0;
  logic [31:0] seenL, seenR;
  logic [31:0] wv [4];

  aud_serial_rx dut (
    .clk(clk), .rstN(rstN), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .fmt(fmt), .wordLen(wordLen), .tdmEn(tdmEn), .tdmSlot(tdmSlot),
    .leftSrc(leftSrc), .rightSrc(rightSrc),
    .leftOut(leftOut), .rightOut(rightOut), .outValid(outValid)
  );

  always @(negedge clk) if (rstN && outValid) begin
    nValid++;
    seenL = leftOut;
    seenR = rightOut;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wlBits(input logic [1:0] c);
    return (c == 2'b00) ? 16 : (c == 2'b01) ? 20 : (c == 2'b10) ? 24 : 32;
  endfunction

  function automatic logic [1:0] genBit(input int g);
    int w, h, i, st;
    logic lr, d;
    w = wlBits(wordLen); h = g / 64; i = g % 64;
    lr = h[0]; d = 1'b1;
    case (fmt)
      2'b01: for (int s = 0; s < 2; s++)
        if ((s == 0 || tdmEn) && i >= s*w && i < s*w + w) d = wv[2*s+h][31-(i-s*w)];
      2'b10: for (int s = 0; s < 2; s++)
        if ((s == 0 || tdmEn) && i-1 >= s*w && i-1 < s*w + w) d = wv[2*s+h][31-(i-1-s*w)];
      2'b00: begin
        if (!tdmEn) begin
          st = 64 - w;
          if (i >= st) d = wv[h][31-(i-st)];
        end else for (int s = 0; s < 2; s++) begin
          st = 64 - (2-s)*w;
          if (i >= st && i < st + w) d = wv[2*s+h][31-(i-st)];
        end
      end
      default: begin
        lr = (g == 0);
        if (g / w < (tdmEn ? 4 : 2)) d = wv[g/w][31-(g%w)];
      end
    endcase
    return {lr, d};
  endfunction

  task automatic sendTick(input logic lr, input logic d);
    @(negedge clk); bclk = 1'b0; lrclk = lr; sdata = d;
    @(negedge clk);
    @(negedge clk); bclk = 1'b1;
    @(negedge clk); sdata = ~d;   // change while bit clock high: must be ignored (R12)
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; bclk = 1'b0; lrclk = 1'b1; sdata = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Runs one frame and checks valid count and both outputs
  task automatic runFrame(input string req, input logic [1:0] f, input logic [1:0] wl,
                          input logic tdm, input logic slot, input logic ls, input logic rs);
    logic [1:0] b;
    logic [31:0] mask, lw, rw;
    int s;
    fmt = f; wordLen = wl; tdmEn = tdm; tdmSlot = slot; leftSrc = ls; rightSrc = rs;
    doReset();
    nValid = 0;
    repeat (3) sendTick(f != 2'b11, 1'b1);
    for (int g = 0; g < 128; g++) begin
      b = genBit(g);
      sendTick(b[1], b[0]);
    end
    repeat (4) sendTick(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    mask = 32'hFFFF_FFFF << (32 - wlBits(wl));
    s = tdm ? int'(slot) : 0;
    lw = wv[2*s] & mask;
    rw = wv[2*s+1] & mask;
    check({req, " R10 valid count"}, 32'(nValid), 32'd1);
    check({req, " left"},  seenL, ls ? rw : lw);
    check({req, " right"}, seenR, rs ? rw : lw);
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk);
    check("R11 leftOut", leftOut, 32'h0);
    check("R11 rightOut", rightOut, 32'h0);
    check("R11 outValid", {31'h0, outValid}, 32'h0);
  endtask

  task automatic testLeftAligned();
    wv[0] = 32'hA5C3_1E77; wv[1] = 32'h3C96_0F12; wv[2] = 32'h0; wv[3] = 32'h0;
    runFrame("R1 R12 LJ 24b", 2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1);
    wv[0] = 32'h8001_0000; wv[1] = 32'h7FFE_0000;
    runFrame("R6 LJ 16b tail", 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testDelayed();
    wv[0] = 32'hC0DE_0000; wv[1] = 32'h1234_0000;
    runFrame("R2 DLY 16b", 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testRightAligned();
    wv[0] = 32'h4B2F_0000; wv[1] = 32'hD00D_0000;
    runFrame("R3 R5 RJ 16b", 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
    wv[0] = 32'h9ABC_D000; wv[1] = 32'h0246_8000;
    runFrame("R3 R5 RJ 20b", 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testPulse();
    wv[0] = 32'hFEDC_BA98; wv[1] = 32'h0123_4567;
    runFrame("R4 R5 PLS 32b", 2'b11, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testTdm();
    wv[0] = 32'h1111_1100; wv[1] = 32'h2222_2200; wv[2] = 32'hA1B2_C300; wv[3] = 32'h5D6E_7F00;
    runFrame("R9 TDM LJ slot1", 2'b01, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1);
    wv[0] = 32'h1357_0000; wv[1] = 32'h2468_0000; wv[2] = 32'hBEEF_0000; wv[3] = 32'hCAFE_0000;
    runFrame("R9 TDM PLS slot1", 2'b11, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1);
    runFrame("R9 TDM RJ slot0", 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1);
    runFrame("R9 TDM RJ slot1", 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic testSources();
    wv[0] = 32'h6A6A_6A00; wv[1] = 32'h9595_9500; wv[2] = 32'h0; wv[3] = 32'h0;
    runFrame("R7 R8 swap", 2'b01, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0);
    runFrame("R7 R8 dup left", 2'b10, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    runFrame("R7 R8 dup right", 2'b00, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    testReset();
    testLeftAligned();
    testDelayed();
    testRightAligned();
    testPulse();
    testTdm();
    testSources();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule